// File: doc/BRIEF.md
# Hierarchical Channel Poll Scheduler

This block decides which queue-monitoring channel is serviced next. Channels are split into a high-priority group, indices `0` to `N_HI-1`, and a low-priority group, indices `N_HI` to `N_HI+N_LO-1`. The block offers one channel index at a time on a valid/done handshake. The downstream poller does the work for that channel, then pulses done. The scheduler holds the index until then, and then moves on.

In mixed mode the high-priority channels are swept in ascending order, again and again. Between two sweeps exactly one low-priority channel is slipped in, and the low-priority channel chosen rotates each time. In flat mode there is no split: every channel takes part in one plain round robin.

Each channel has an enable bit. A disabled channel is passed over within the same selection decision, so it never costs a poll slot. The block only decides the order of polling. The poll work itself and any interrupt pacing belong to other logic.

Top module: `chan_poll_sched`

## Requirements
- R1: While `rst` is high, `poll_valid` is 0. After reset, the high-priority position and the low-priority position both start at channel 0. With every channel enabled, the first channel offered is channel 0, one cycle after `rst` falls.
- R2: While `poll_valid` is 1 and `poll_done` is 0, `poll_chan` and `poll_valid` stay unchanged on the next cycle.
- R3: With `flat_mode` at 0, a sweep offers the enabled high-priority channels (indices below `N_HI`) in strictly ascending order.
- R4: With `flat_mode` at 0, exactly one low-priority channel (index `N_HI` or above) is offered after each completed high-priority sweep, provided at least one low-priority channel is enabled. The next high-priority sweep then restarts from channel 0.
- R5: Each inserted low-priority slot takes the next enabled low-priority channel after the one used last, wrapping from `N_HI+N_LO-1` back to `N_HI`.
- R6: A channel whose `chan_en` bit is 0 when the next selection is made is never offered. When at least one channel is enabled, `poll_valid` is 1 in the cycle after an accepted poll, so skipping costs no cycle.
- R7: With `flat_mode` at 0 and no low-priority channel enabled, the low-priority slot is left out and high-priority sweeps follow one another directly.
- R8: With `flat_mode` at 1, all `N_HI+N_LO` channels are offered in ascending round-robin order with wraparound, and disabled channels are skipped.
- R9: If `chan_en` is all zeros when a selection is made, `poll_valid` is 0 in the next cycle.
- R10: Whenever `poll_valid` is 1, `poll_chan` is below `N_HI+N_LO`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flat_mode | input | 1 | 1 selects the flat round robin, 0 selects the mixed schedule |
| chan_en | input | N_HI+N_LO | Per-channel enable, bit i for channel i |
| poll_valid | output | 1 | A channel index is offered |
| poll_chan | output | clog2(N_HI+N_LO) | Offered channel index |
| poll_done | input | 1 | The offered poll is finished. The next selection is taken at this edge. |

## Verification
The bench builds the scheduler with five high-priority and three low-priority channels, a total of eight. With these values a full sweep lasts only a few polls, so the low-priority rotation wraps around many times within a short run. The small width also lets random enable masks often land on the corners: an empty low group, an empty high group, a single enabled channel and an all-zero mask. Flat mode is run in a separate pass after reset, over the same eight channels.

// File: rtl/cps_pkg.sv
package cps_pkg;

    // Where the next offered channel comes from
    typedef enum logic [2:0] {
        SRC_NONE       = 3'd0,
        SRC_HI_CONT    = 3'd1,
        SRC_LO_SLOT    = 3'd2,
        SRC_HI_RESTART = 3'd3,
        SRC_FLAT       = 3'd4
    } pick_src_e;

    typedef enum logic {
        SCHED_MIXED = 1'b0,
        SCHED_FLAT  = 1'b1
    } sched_mode_e;

endpackage

// File: rtl/cps_find.sv
// First set bit of a mask at or after a start position, optionally wrapping.
module cps_find #(
    parameter int W  = 8,
    parameter int SW = $clog2(W + 1)
) (
    input  logic [W-1:0]  mask,
    input  logic [SW-1:0] start,
    input  logic          wrap,
    output logic          found,
    output logic [SW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < W; k++) begin
            int  pos;
            logic ok;
            pos = int'(start) + k;
            ok  = 1'b1;
            if (pos >= W) begin
                if (wrap) pos = pos - W;
                else      ok  = 1'b0;
            end
            if (ok && !found && mask[pos]) begin
                found = 1'b1;
                idx   = SW'(pos);
            end
        end
    end
endmodule

// File: rtl/cps_select.sv
// Combinational choice of the next channel and the pointer updates.
module cps_select
    import cps_pkg::*;
#(
    parameter int N_HI = 32,
    parameter int N_LO = 16,
    localparam int NCH = N_HI + N_LO,
    localparam int CW  = $clog2(NCH),
    localparam int HSW = $clog2(N_HI + 1),
    localparam int LSW = $clog2(N_LO + 1),
    localparam int FSW = $clog2(NCH + 1)
) (
    input  sched_mode_e    mode,
    input  logic [NCH-1:0] en,
    input  logic [HSW-1:0] hi_ptr,
    input  logic [LSW-1:0] lo_ptr,
    input  logic [FSW-1:0] fl_ptr,
    output logic           found,
    output logic [CW-1:0]  chan,
    output pick_src_e      src,
    output logic [HSW-1:0] hi_ptr_n,
    output logic [LSW-1:0] lo_ptr_n,
    output logic [FSW-1:0] fl_ptr_n
);
    logic [N_HI-1:0] hi_mask;
    logic [N_LO-1:0] lo_mask;
    logic            hc_found, hr_found, lo_found, fl_found;
    logic [HSW-1:0]  hc_idx, hr_idx;
    logic [LSW-1:0]  lo_idx;
    logic [FSW-1:0]  fl_idx;

    assign hi_mask = en[N_HI-1:0];
    assign lo_mask = en[NCH-1:N_HI];

    // continue the running sweep (no wrap)
    cps_find #(.W(N_HI), .SW(HSW)) u_hcont (
        .mask(hi_mask), .start(hi_ptr), .wrap(1'b0),
        .found(hc_found), .idx(hc_idx));
    // start a fresh sweep from channel 0
    cps_find #(.W(N_HI), .SW(HSW)) u_hrst (
        .mask(hi_mask), .start('0), .wrap(1'b0),
        .found(hr_found), .idx(hr_idx));
    // rotating low-priority slot
    cps_find #(.W(N_LO), .SW(LSW)) u_lo (
        .mask(lo_mask), .start(lo_ptr), .wrap(1'b1),
        .found(lo_found), .idx(lo_idx));
    // flat round robin over every channel
    cps_find #(.W(NCH), .SW(FSW)) u_flat (
        .mask(en), .start(fl_ptr), .wrap(1'b1),
        .found(fl_found), .idx(fl_idx));

    always_comb begin
        src = SRC_NONE;
        if (mode == SCHED_FLAT) begin
            if (fl_found) src = SRC_FLAT;
        end else if (hc_found) begin
            src = SRC_HI_CONT;
        end else if (lo_found) begin
            src = SRC_LO_SLOT;
        end else if (hr_found) begin
            src = SRC_HI_RESTART;
        end
    end

    always_comb begin
        found    = (src != SRC_NONE);
        chan     = '0;
        hi_ptr_n = hi_ptr;
        lo_ptr_n = lo_ptr;
        fl_ptr_n = fl_ptr;
        unique case (src)
            SRC_HI_CONT: begin
                chan     = CW'(hc_idx);
                hi_ptr_n = hc_idx + HSW'(1);
            end
            SRC_HI_RESTART: begin
                chan     = CW'(hr_idx);
                hi_ptr_n = hr_idx + HSW'(1);
            end
            SRC_LO_SLOT: begin
                chan     = CW'(N_HI) + CW'(lo_idx);
                hi_ptr_n = '0;
                lo_ptr_n = (lo_idx == LSW'(N_LO - 1)) ? '0 : lo_idx + LSW'(1);
            end
            SRC_FLAT: begin
                chan     = CW'(fl_idx);
                fl_ptr_n = (fl_idx == FSW'(NCH - 1)) ? '0 : fl_idx + FSW'(1);
            end
            default: begin
                if (mode == SCHED_MIXED) hi_ptr_n = '0;
            end
        endcase
    end
endmodule

// File: rtl/chan_poll_sched.sv
module chan_poll_sched
    import cps_pkg::*;
#(
    parameter int N_HI = 32,
    parameter int N_LO = 16,
    localparam int NCH = N_HI + N_LO,
    localparam int CW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           flat_mode,
    input  logic [NCH-1:0] chan_en,
    output logic           poll_valid,
    output logic [CW-1:0]  poll_chan,
    input  logic           poll_done
);
    localparam int HSW = $clog2(N_HI + 1);
    localparam int LSW = $clog2(N_LO + 1);
    localparam int FSW = $clog2(NCH + 1);

    logic [HSW-1:0] hi_ptr, hi_ptr_n;
    logic [LSW-1:0] lo_ptr, lo_ptr_n;
    logic [FSW-1:0] fl_ptr, fl_ptr_n;
    logic           sel_found;
    logic [CW-1:0]  sel_chan;
    pick_src_e      sel_src;
    sched_mode_e    mode;
    logic           load;

    assign mode = flat_mode ? SCHED_FLAT : SCHED_MIXED;
    assign load = !poll_valid || poll_done;

    cps_select #(.N_HI(N_HI), .N_LO(N_LO)) u_sel (
        .mode(mode), .en(chan_en),
        .hi_ptr(hi_ptr), .lo_ptr(lo_ptr), .fl_ptr(fl_ptr),
        .found(sel_found), .chan(sel_chan), .src(sel_src),
        .hi_ptr_n(hi_ptr_n), .lo_ptr_n(lo_ptr_n), .fl_ptr_n(fl_ptr_n));

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_ptr     <= '0;
            lo_ptr     <= '0;
            fl_ptr     <= '0;
            poll_valid <= 1'b0;
            poll_chan  <= '0;
        end else if (load) begin
            hi_ptr     <= hi_ptr_n;
            lo_ptr     <= lo_ptr_n;
            fl_ptr     <= fl_ptr_n;
            poll_valid <= sel_found;
            poll_chan  <= sel_found ? sel_chan : poll_chan;
        end
    end
endmodule

// File: rtl/cps_checker.sv
module cps_checker #(
    parameter int N_HI = 32,
    parameter int N_LO = 16,
    localparam int NCH = N_HI + N_LO,
    localparam int CW  = $clog2(NCH)
) (
    input logic           clk,
    input logic           rst,
    input logic           flat_mode,
    input logic [NCH-1:0] chan_en,
    input logic           poll_valid,
    input logic [CW-1:0]  poll_chan,
    input logic           poll_done
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !poll_valid); // R1

    AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
        poll_valid && !poll_done |=> poll_valid && $stable(poll_chan)); // R2

    AST_SWEEP_ASCENDS: assert property (@(posedge clk) disable iff (rst)
        poll_valid && poll_done && !flat_mode && (int'(poll_chan) < N_HI)
        && (|chan_en[NCH-1:N_HI])
        |=> (int'(poll_chan) >= N_HI) || (poll_chan > $past(poll_chan))); // R3

    AST_LO_THEN_HI: assert property (@(posedge clk) disable iff (rst)
        poll_valid && poll_done && !flat_mode && (int'(poll_chan) >= N_HI)
        && (|chan_en[N_HI-1:0])
        |=> int'(poll_chan) < N_HI); // R4

    AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        (!poll_valid || poll_done) && (|chan_en) |=> poll_valid); // R6

    AST_IDLE_WHEN_NONE: assert property (@(posedge clk) disable iff (rst)
        (!poll_valid || poll_done) && (chan_en == '0) |=> !poll_valid); // R9

    AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (rst)
        poll_valid |-> int'(poll_chan) < NCH); // R10
endmodule

bind chan_poll_sched cps_checker #(.N_HI(N_HI), .N_LO(N_LO)) u_cps_checker (
    .clk(clk), .rst(rst), .flat_mode(flat_mode), .chan_en(chan_en),
    .poll_valid(poll_valid), .poll_chan(poll_chan), .poll_done(poll_done));

// File: tb/chan_poll_sched_test.sv
module chan_poll_sched_test;
    localparam int NH  = 5;
    localparam int NL  = 3;
    localparam int NC  = NH + NL;
    localparam int CWT = $clog2(NC);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           flat_mode = 1'b0;
    logic [NC-1:0]  chan_en = '1;
    logic           poll_done = 1'b0;
    logic           poll_valid;
    logic [CWT-1:0] poll_chan;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    chan_poll_sched #(.N_HI(NH), .N_LO(NL)) uut (
        .clk(clk), .rst(rst), .flat_mode(flat_mode), .chan_en(chan_en),
        .poll_valid(poll_valid), .poll_chan(poll_chan), .poll_done(poll_done));

    // reference schedule state
    bit m_vld;
    int m_ch, hp, lp, fp;

    function automatic int scan(input logic [NC-1:0] en, input int base,
                                input int cnt, input int from, input bit wr);
        for (int k = 0; k < cnt; k++) begin
            int p = from + k;
            if (p >= cnt) begin
                if (!wr) return -1;
                p = p - cnt;
            end
            if (en[base + p]) return p;
        end
        return -1;
    endfunction

    task automatic model_next();
        int r;
        if (flat_mode) begin
            r = scan(chan_en, 0, NC, fp, 1'b1);
            m_vld = (r >= 0);
            if (r >= 0) begin m_ch = r; fp = (r + 1) % NC; end
        end else begin
            r = scan(chan_en, 0, NH, hp, 1'b0);
            if (r >= 0) begin
                m_vld = 1'b1; m_ch = r; hp = r + 1;
            end else begin
                r = scan(chan_en, NH, NL, lp, 1'b1);
                if (r >= 0) begin
                    m_vld = 1'b1; m_ch = NH + r; lp = (r + 1) % NL; hp = 0;
                end else begin
                    r = scan(chan_en, 0, NH, 0, 1'b0);
                    m_vld = (r >= 0);
                    hp = (r >= 0) ? r + 1 : 0;
                    if (r >= 0) m_ch = r;
                end
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_vld = 1'b0; m_ch = 0; hp = 0; lp = 0; fp = 0;
        end else if (!m_vld || poll_done) begin
            model_next();
        end
    end

    task automatic check(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    bit            p_vld, p_done;
    logic [CWT-1:0] p_ch;

    // one cycle: sample at negedge, then drive new inputs
    task automatic step(input bit d, input logic [NC-1:0] en);
        @(negedge clk);
        if (!rst) begin
            check({tag, " valid"}, poll_valid == m_vld, poll_valid, m_vld);
            if (m_vld)
                check({tag, " chan"}, int'(poll_chan) == m_ch, poll_chan, m_ch);
            if (poll_valid)
                check("R10", int'(poll_chan) < NC, poll_chan, NC - 1);
            if (p_vld && !p_done)
                check("R2 hold", poll_valid && poll_chan == p_ch, poll_chan, p_ch);
        end
        p_vld = poll_valid; p_ch = poll_chan; p_done = d;
        poll_done = d;
        chan_en   = en;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        p_vld = 0; p_done = 0;
        // R1: idle during reset
        repeat (3) @(negedge clk);
        check("R1 reset", poll_valid == 1'b0, poll_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 first", poll_valid && poll_chan == 0, poll_chan, 0);
        p_vld = poll_valid; p_ch = poll_chan; p_done = 1'b1;
        poll_done = 1'b1;

        // R3/R4/R5: all enabled, back-to-back accept; directed order
        tag = "R4";
        begin
            int exp_seq[20] = '{1,2,3,4,5,0,1,2,3,4,6,0,1,2,3,4,7,0,1,2};
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                check(i == 4 || i == 10 || i == 16 ? "R5 lo rotate" : "R3 sweep",
                      poll_valid && int'(poll_chan) == exp_seq[i], poll_chan, exp_seq[i]);
                checks++;
                if (!(poll_valid == m_vld && int'(poll_chan) == m_ch)) begin
                    errors++;
                    $display("FAIL R4 model actual=%0d expected=%0d", poll_chan, m_ch);
                end
            end
            p_vld = poll_valid; p_ch = poll_chan;
        end

        // R2/R6: random done and random enables
        tag = "R6";
        for (int i = 0; i < 600; i++)
            step(($urandom % 10) < 7, NC'($urandom));

        // R7: low group disabled, sweeps back to back
        tag = "R7";
        for (int i = 0; i < 200; i++)
            step(($urandom % 10) < 8, {{NL{1'b0}}, NH'($urandom) | NH'(1)});

        // R5: low only, rotation with wrap
        tag = "R5";
        for (int i = 0; i < 60; i++)
            step(1'b1, {NL'($urandom) | NL'(1), {NH{1'b0}}});

        // R9: nothing enabled
        tag = "R9";
        for (int i = 0; i < 10; i++) step(1'b1, '0);
        step(1'b1, '0);
        check("R9 idle", poll_valid == 1'b0, poll_valid, 0);
        for (int i = 0; i < 20; i++) step(($urandom % 2) == 1, NC'(1) << ($urandom % NC));

        // R8: flat mode after reset
        @(negedge clk);
        rst = 1'b1; flat_mode = 1'b1; chan_en = '1; poll_done = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0; p_vld = 0;
        tag = "R8";
        for (int i = 0; i < 20; i++) step(1'b1, '1);
        for (int i = 0; i < 400; i++)
            step(($urandom % 10) < 7, NC'($urandom));

        // back to mixed mode, random mix
        @(negedge clk);
        rst = 1'b1; flat_mode = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0; p_vld = 0;
        tag = "R3";
        for (int i = 0; i < 400; i++)
            step(($urandom % 10) < 6, ($urandom % 4 == 0) ? NC'($urandom) : '1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule